// File: doc/BRIEF.md
# Adaptive Output Direction Selector

This block is the first arbitration stage of a three-dimensional torus router. Once per clock it looks at the packet waiting at the head of an injection queue or a virtual-channel queue. It then picks the single output direction and virtual channel (VC) that the packet should ask for in the later arbitration stages.

The choice is built from four things: the six direction hint bits in the packet header, the packet's routing class (adaptive or fixed-path), a per-direction, per-VC availability vector from the output ports, and a coarse two-bit measure of free downstream buffer space for every direction and VC.

- **Adaptive packets** go where the most downstream space is reported. Equal candidates are split by a pseudo-random source.
- **Fallback:** when no adaptive lane is open, an adaptive packet drops back to the deadlock-free escape lane.
- **Fixed-path packets** only ever use the escape lane, taken in x, then y, then z order.
- **Packets at their destination** ask for the local reception queue.

The request is registered and appears one clock after its inputs.

Top module: `adaptive_dir_sel`

## Requirements
- R1: While `rst_n` is low at a rising edge, `req_valid` is 0 after that edge, and it stays 0 until a legal request is registered after reset is released.
- R2: An adaptive request targets only a direction d whose hint bit `hint[d]` is set, on an adaptive VC v (0 or 1) whose availability bit `avail[d*3+v]` is set. Direction codes are 0..5 = x+, x-, y+, y-, z+, z-, and `hint[i]` belongs to direction code i.
- R3: Among the open adaptive candidates, the one with the largest token range `tok_range[(d*3+v)*2 +: 2]` is requested, so a closed or unhinted lane with a higher range is never chosen.
- R4: Candidates that tie on the best range are resolved as follows.
  - Each adaptive candidate gets the index d*2+v.
  - The search starts at index S = L mod 12, where L is an 8-bit shift register seeded to 0x5A in reset.
  - L advances on every clock after reset: it shifts left and takes into bit 0 the XOR of its bits 7, 5, 4 and 3.
  - The winner is the first tied index met scanning upward from S with wrap-around.
- R5: An adaptive packet with no open adaptive candidate requests its escape direction on VC 2, provided `avail[e*3+2]` is set for that escape direction e.
- R6: The escape direction is taken from the lowest dimension (x, then y, then z) that has a nonzero hint pair. Its sign follows the set hint bit.
- R7: A fixed-path packet (`is_dynamic`=0) requests only its escape direction on VC 2, whatever the adaptive availability and token ranges show.
- R8: `req_valid` is 0 after any cycle with no legal request: `head_valid` low, the needed escape lane unavailable, or no hint bit set while not at destination.
- R9: A packet with `at_dest` set requests direction code 6 (local reception) on VC 0, whatever its hints and availability.
- R10: The request is registered. Outputs change only at the rising edge following the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| head_valid | input | 1 | A packet is waiting at the queue head |
| hint | input | 6 | Direction hint bits, bit i for direction code i |
| is_dynamic | input | 1 | 1 = adaptive packet, 0 = fixed-path packet |
| at_dest | input | 1 | Packet has reached its destination node |
| avail | input | 18 | Lane open flags, bit d*3+v for direction d and VC v |
| tok_range | input | 36 | Two-bit free-space range per lane, bits (d*3+v)*2 +: 2 |
| req_valid | output | 1 | A request is presented |
| req_dir | output | 3 | Requested direction code (0..5 link, 6 local) |
| req_vc | output | 2 | Requested VC (0..1 adaptive, 2 escape) |

## Verification
The bench builds the block with its default parameters: three dimensions, two adaptive VCs plus one escape VC, two-bit token ranges and an 8-bit shift register seeded to 0x5A. With these values there are twelve adaptive candidates, which is few enough to reach every kind of case in a short run:
- masking of a high-range lane by a missing hint or a closed availability bit;
- escape fallback in each dimension order;
- four-way ties whose winner moves with the known shift-register sequence, so the random split is checked cycle by cycle.

// File: rtl/dirsel_pkg.sv
// Package: shared constants and types for the adaptive output direction selector.
// Assumes a torus with a plus and a minus link per dimension.
package dirsel_pkg;
    localparam int DEF_DIMS   = 3;
    localparam int DEF_DYN_VC = 2;
    localparam int DEF_TOK_W  = 2;

    // Source of the next request, used to steer the output mux.
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LOCAL = 2'd1,
        SRC_DYN   = 2'd2,
        SRC_ESC   = 2'd3
    } req_src_e;
endpackage

// File: rtl/sel_lfsr.sv
// Module: free-running Fibonacci shift register used as the tie-break source.
// Shifts left each clock and feeds the XOR of the tapped bits into bit 0.
// Assumes TAPS has at least one bit set and SEED is nonzero.
module sel_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h5A
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    // Advance the sequence every clock; load the seed in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= {state[W-2:0], ^(state & TAPS)};
    end
endmodule

// File: rtl/sel_escape.sv
// Module: finds the dimension-ordered escape direction from the hint bits.
// The lowest dimension with a nonzero hint pair wins; the plus bit sets sign 0,
// the minus bit sign 1. Assumes at most one bit of each pair is set.
module sel_escape #(
    parameter int N_DIM = 3,
    parameter int DIR_W = 3
) (
    input  logic [2*N_DIM-1:0] hint,
    output logic               esc_ok,
    output logic [DIR_W-1:0]   esc_dir
);
    logic [N_DIM-1:0] dim_has;

    // One flag per dimension: any hop left in it.
    for (genvar g = 0; g < N_DIM; g++) begin : g_dim
        assign dim_has[g] = hint[2*g] | hint[2*g+1];
    end

    // Scan from the highest dimension down so the lowest one is kept last.
    always_comb begin
        esc_ok  = 1'b0;
        esc_dir = '0;
        for (int d = N_DIM - 1; d >= 0; d--) begin
            if (dim_has[d]) begin
                esc_ok  = 1'b1;
                esc_dir = DIR_W'(2*d + (hint[2*d] ? 0 : 1));
            end
        end
    end
endmodule

// File: rtl/sel_jsq.sv
// Module: join-the-shortest-queue pick over adaptive candidates.
// Chooses the candidate with the largest token range. Ties are broken by
// taking the first tied index at or after (rnd mod N_CAND), with wrap-around.
// Purely combinational.
module sel_jsq #(
    parameter int N_CAND = 12,
    parameter int TOK_W  = 2,
    parameter int RND_W  = 8,
    localparam int CAND_W = $clog2(N_CAND)
) (
    input  logic [N_CAND-1:0]       cand,
    input  logic [N_CAND*TOK_W-1:0] tok,
    input  logic [RND_W-1:0]        rnd,
    output logic                    win_valid,
    output logic [CAND_W-1:0]       win_idx
);
    logic [TOK_W-1:0]  best;
    logic [N_CAND-1:0] tied;
    int                start;

    // Highest token range seen among live candidates.
    always_comb begin
        best = '0;
        for (int i = 0; i < N_CAND; i++) begin
            if (cand[i] && tok[i*TOK_W +: TOK_W] > best) best = tok[i*TOK_W +: TOK_W];
        end
    end

    // Candidates sitting at that best range.
    always_comb begin
        for (int i = 0; i < N_CAND; i++) begin
            tied[i] = cand[i] && (tok[i*TOK_W +: TOK_W] == best);
        end
    end

    // Rotating first-found search among the tied set.
    always_comb begin
        start     = int'(rnd) % N_CAND;
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = 0; i < N_CAND; i++) begin
            if (!win_valid && tied[(start + i) % N_CAND]) begin
                win_valid = 1'b1;
                win_idx   = CAND_W'((start + i) % N_CAND);
            end
        end
    end
endmodule

// File: rtl/adaptive_dir_sel.sv
// Module: top of the first-stage direction/VC selector of a torus router.
// Builds adaptive candidates from hints AND availability, picks by token range
// (random tie-break), falls back to the escape lane, and registers the result.
// Assumes escape VC index = N_DYN_VC and the local reception code = N_DIR.
module adaptive_dir_sel
    import dirsel_pkg::*;
#(
    parameter int          N_DIM     = DEF_DIMS,
    parameter int          N_DYN_VC  = DEF_DYN_VC,
    parameter int          TOK_W     = DEF_TOK_W,
    parameter int          LFSR_W    = 8,
    parameter logic [7:0]  LFSR_TAPS = 8'hB8,
    parameter logic [7:0]  LFSR_SEED = 8'h5A,
    localparam int N_DIR  = 2 * N_DIM,
    localparam int N_VC   = N_DYN_VC + 1,
    localparam int ESC_VC = N_DYN_VC,
    localparam int N_CAND = N_DIR * N_DYN_VC,
    localparam int N_LANE = N_DIR * N_VC,
    localparam int DIR_W  = $clog2(N_DIR + 1),
    localparam int VC_W   = $clog2(N_VC),
    localparam int CAND_W = $clog2(N_CAND)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     head_valid,
    input  logic [N_DIR-1:0]         hint,
    input  logic                     is_dynamic,
    input  logic                     at_dest,
    input  logic [N_LANE-1:0]        avail,
    input  logic [N_LANE*TOK_W-1:0]  tok_range,
    output logic                     req_valid,
    output logic [DIR_W-1:0]         req_dir,
    output logic [VC_W-1:0]          req_vc
);
    localparam logic [DIR_W-1:0] LOCAL_DIR = DIR_W'(N_DIR);

    logic [N_CAND-1:0]       cand;
    logic [N_CAND*TOK_W-1:0] cand_tok;
    logic [LFSR_W-1:0]       rnd;
    logic                    win_valid;
    logic [CAND_W-1:0]       win_idx;
    logic                    esc_ok;
    logic [DIR_W-1:0]        esc_dir;
    logic                    esc_open;
    req_src_e                src;
    logic                    nxt_valid;
    logic [DIR_W-1:0]        nxt_dir;
    logic [VC_W-1:0]         nxt_vc;

    // Adaptive lanes: hint of the direction AND the lane's open flag.
    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        for (genvar v = 0; v < N_DYN_VC; v++) begin : g_vc
            assign cand[d*N_DYN_VC+v] = hint[d] & avail[d*N_VC+v];
            assign cand_tok[(d*N_DYN_VC+v)*TOK_W +: TOK_W] =
                tok_range[(d*N_VC+v)*TOK_W +: TOK_W];
        end
    end

    sel_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (rnd)
    );

    sel_jsq #(.N_CAND(N_CAND), .TOK_W(TOK_W), .RND_W(LFSR_W)) u_jsq (
        .cand      (cand),
        .tok       (cand_tok),
        .rnd       (rnd),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    sel_escape #(.N_DIM(N_DIM), .DIR_W(DIR_W)) u_esc (
        .hint    (hint),
        .esc_ok  (esc_ok),
        .esc_dir (esc_dir)
    );

    // Open flag of the escape lane in the escape direction.
    always_comb begin
        esc_open = 1'b0;
        for (int d = 0; d < N_DIR; d++) begin
            if (esc_ok && esc_dir == DIR_W'(d)) esc_open = avail[d*N_VC+ESC_VC];
        end
    end

    // Priority of sources: local delivery, adaptive pick, escape, none.
    always_comb begin
        if (!head_valid)                  src = SRC_NONE;
        else if (at_dest)                 src = SRC_LOCAL;
        else if (is_dynamic && win_valid) src = SRC_DYN;
        else if (esc_ok && esc_open)      src = SRC_ESC;
        else                              src = SRC_NONE;
    end

    // Steer the chosen source onto the next-request fields.
    always_comb begin
        nxt_valid = (src != SRC_NONE);
        nxt_dir   = '0;
        nxt_vc    = '0;
        case (src)
            SRC_LOCAL: nxt_dir = LOCAL_DIR;
            SRC_DYN: begin
                nxt_dir = DIR_W'(win_idx / CAND_W'(N_DYN_VC));
                nxt_vc  = VC_W'(win_idx % CAND_W'(N_DYN_VC));
            end
            SRC_ESC: begin
                nxt_dir = esc_dir;
                nxt_vc  = VC_W'(ESC_VC);
            end
            default: ;
        endcase
    end

    // Output register for the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_dir   <= '0;
            req_vc    <= '0;
        end else begin
            req_valid <= nxt_valid;
            req_dir   <= nxt_dir;
            req_vc    <= nxt_vc;
        end
    end

    // R1: reset clears the request.
    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !req_valid);

    // R2: a link request is hinted and open.
    p_hint_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_valid && nxt_dir != LOCAL_DIR) |->
        (((hint >> nxt_dir) & 1'b1) != 0) &&
        (((avail >> (nxt_dir * N_VC + nxt_vc)) & 1'b1) != 0));

    // R3: the JSQ winner is a live candidate.
    p_win_cand_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> cand[win_idx]);

    // R7: a fixed-path packet only uses the escape VC.
    p_det_escape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !at_dest && !is_dynamic && nxt_valid) |-> nxt_vc == VC_W'(ESC_VC));

    // R8: no waiting packet gives no request.
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !head_valid |=> !req_valid);

    // R9: a packet at its destination goes to local reception.
    p_local_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && at_dest) |=> (req_valid && req_dir == LOCAL_DIR && req_vc == '0));
endmodule

// File: tb/tb_adaptive_dir_sel.sv
`timescale 1ns/1ps
module tb_adaptive_dir_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        head_valid, is_dynamic, at_dest;
    logic [5:0]  hint;
    logic [17:0] avail;
    logic [35:0] tok_range;
    logic        req_valid;
    logic [2:0]  req_dir;
    logic [1:0]  req_vc;
    logic [7:0]  mdl;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    adaptive_dir_sel dut (
        .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .hint(hint),
        .is_dynamic(is_dynamic), .at_dest(at_dest), .avail(avail),
        .tok_range(tok_range), .req_valid(req_valid), .req_dir(req_dir), .req_vc(req_vc)
    );

    // Model of the tie-break register as R4 states it.
    always @(posedge clk) begin
        if (!rst_n) mdl <= 8'h5A;
        else        mdl <= {mdl[6:0], mdl[7] ^ mdl[5] ^ mdl[4] ^ mdl[3]};
    end

    typedef struct packed {
        logic [3:0]  tag;
        logic        hv;
        logic        dyn;
        logic        dest;
        logic [5:0]  hint;
        logic [17:0] avail;
        logic [35:0] tok;
        logic        ev;
        logic [2:0]  edir;
        logic [1:0]  evc;
    } vec_t;

    localparam vec_t VECS [0:10] = '{
        // R3: y+ vc0 has range 3; masked x- and escape lanes with range 3 lose
        '{4'd3, 1'b1, 1'b1, 1'b0, 6'b000101, 18'h3FFFF, 36'h0000030F9, 1'b1, 3'd2, 2'd0},
        // R2: y+ vc0 closed, x+ vc1 range 2 wins
        '{4'd2, 1'b1, 1'b1, 1'b0, 6'b000101, 18'h3FFBF, 36'h0000030F9, 1'b1, 3'd0, 2'd1},
        // R5: only the x- escape lane is open
        '{4'd5, 1'b1, 1'b1, 1'b0, 6'b000010, 18'h00020, 36'h0, 1'b1, 3'd1, 2'd2},
        // R8: escape lane closed too
        '{4'd8, 1'b1, 1'b1, 1'b0, 6'b000010, 18'h00000, 36'h0, 1'b0, 3'd0, 2'd0},
        // R7: fixed-path, y- before z+, range on z+ ignored
        '{4'd7, 1'b1, 1'b0, 1'b0, 6'b011000, 18'h3FFFF, 36'hF000000, 1'b1, 3'd3, 2'd2},
        // R7: fixed-path, z- escape closed, open adaptive lanes unused
        '{4'd7, 1'b1, 1'b0, 1'b0, 6'b100000, 18'h1FFFF, 36'hFFFFFFFFF, 1'b0, 3'd0, 2'd0},
        // R9: at destination, no hints, nothing open
        '{4'd9, 1'b1, 1'b1, 1'b1, 6'b000000, 18'h00000, 36'h0, 1'b1, 3'd6, 2'd0},
        // R8: no packet at the head
        '{4'd8, 1'b0, 1'b1, 1'b0, 6'b000001, 18'h3FFFF, 36'hFFFFFFFFF, 1'b0, 3'd0, 2'd0},
        // R8: no hints, not at destination
        '{4'd8, 1'b1, 1'b1, 1'b0, 6'b000000, 18'h3FFFF, 36'hFFFFFFFFF, 1'b0, 3'd0, 2'd0},
        // R6: y+ and z- hinted, only escape lanes open: y+ chosen
        '{4'd6, 1'b1, 1'b1, 1'b0, 6'b100100, 18'h24924, 36'h0, 1'b1, 3'd2, 2'd2},
        // R3: z+ vc1 range 3 beats z+ vc0 range 0
        '{4'd3, 1'b1, 1'b1, 1'b0, 6'b010000, 18'h3FFFF, 36'h00C000000, 1'b1, 3'd4, 2'd1}
    };

    task automatic drive(input vec_t v);
        head_valid = v.hv; is_dynamic = v.dyn; at_dest = v.dest;
        hint = v.hint; avail = v.avail; tok_range = v.tok;
    endtask

    task automatic check(input int tag, input logic ev, input logic [2:0] ed, input logic [1:0] evc);
        n_chk++;
        if (req_valid !== ev || (ev && (req_dir !== ed || req_vc !== evc))) begin
            n_bad++;
            $display("FAIL R%0d: got valid=%0b dir=%0d vc=%0d, expected valid=%0b dir=%0d vc=%0d",
                     tag, req_valid, req_dir, req_vc, ev, ed, evc);
        end
    endtask

    // Expected R4 winner among a tie set (adaptive indices d*2+v).
    function automatic int tie_pick(input logic [7:0] l, input logic [11:0] tset);
        int s = int'(l) % 12;
        for (int i = 0; i < 12; i++) begin
            if (tset[(s + i) % 12]) return (s + i) % 12;
        end
        return -1;
    endfunction

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        drive(VECS[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, 1'b0, 3'd0, 2'd0);          // R1: held in reset with a legal request present
        rst_n = 1'b1;
        #1;
        check(10, 1'b0, 3'd0, 2'd0);         // R10: nothing before the next edge
        @(negedge clk);
        check(10, 1'b1, 3'd2, 2'd0);         // R10: appears after one edge

        for (int i = 0; i < 11; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check(int'(VECS[i].tag), VECS[i].ev, VECS[i].edir, VECS[i].evc);
        end

        // R4: four-way tie between x+ and z- adaptive lanes, winner follows the register
        for (int k = 0; k < 8; k++) begin
            int w;
            head_valid = 1'b1; is_dynamic = 1'b1; at_dest = 1'b0;
            hint = 6'b100001; avail = 18'h3FFFF; tok_range = '0;
            w = tie_pick(mdl, 12'hC03);
            @(negedge clk);
            check(4, 1'b1, 3'(w / 2), 2'(w % 2));
        end

        // R4: tie only at the top range; lower-range lanes are never picked
        for (int k = 0; k < 4; k++) begin
            int w;
            hint = 6'b000101; avail = 18'h3FFFF;
            tok_range = 36'h0;
            tok_range[1:0] = 2'd3;    // x+ vc0
            tok_range[15:14] = 2'd3;  // y+ vc1 (lane 7)
            tok_range[3:2] = 2'd1;    // x+ vc1
            w = tie_pick(mdl, 12'h021);
            @(negedge clk);
            check(4, 1'b1, 3'(w / 2), 2'(w % 2));
        end

        // R1: reset in mid-run clears a standing request
        drive(VECS[6]);
        @(negedge clk);
        check(9, 1'b1, 3'd6, 2'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 1'b0, 3'd0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(9, 1'b1, 3'd6, 2'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule